// File: doc/BRIEF.md
# System Reset Sequencer with Watchdog

This block merges every reason a chip may need to restart into one active-low system reset and keeps a record of what caused it. Four sources feed it: the power-on reset, a debounced external reset pin, a brown-out indication gated by its enable, and a watchdog counter that runs on its own slow clock. When any source is active the system reset is driven low. It stays low for a fixed number of system clocks after the last source goes away.

Software sees two small registers. The control register turns the watchdog on and picks its timeout. The cause register holds one flag per source, and software clears a flag by writing 1 to it. A one-cycle service strobe in the system clock domain restarts the watchdog count. The strobe crosses into the watchdog clock domain as a toggle, and a watchdog expiry crosses back the same way.

Any system reset puts the control register back to zero, which disables the watchdog. The cause register is cleared only by power-on, so the record survives the reset it describes.

Top module: `reset_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no_o` is low and the cause register reads 4'b0001, with the other flags cleared. After `rst_ni` rises, `sys_rst_no_o` stays low for HOLD_CYC rising edges of `clk_i` and then goes high.
- R2: When `ext_rst_ni` is held low for fewer than EXT_MIN_CYC system clocks, nothing happens. When it is held low for EXT_MIN_CYC clocks or more, the system reset is asserted and cause bit 1 is set.
- R3: `bod_low_i` causes a reset only while `bod_en_i` is high, and that reset sets cause bit 2. With `bod_en_i` low, `bod_low_i` changes neither the reset output nor the cause register.
- R4: With the watchdog enabled and select value s, the watchdog expires after 2^(WDT_BASE_LOG2+s) cycles of `wdt_clk_i` without service. Each expiry produces a single system reset and sets cause bit 3.
- R5: A pulse on `wdt_srv_i` restarts the watchdog count. A watchdog serviced more often than its period never resets the system.
- R6: While control bit 0 is 0, the watchdog never causes a reset.
- R7: `sys_rst_no_o` goes low one clock after any qualified source is seen. It returns high exactly HOLD_CYC clocks after the last clock in which a source was seen.
- R8: Cause flags accumulate across non-power-on resets. Writing 1 to a cause bit clears that bit, and writing 0 leaves it unchanged. A source that is active in the same cycle as a clearing write wins over the write.
- R9: Any system reset returns the control register to 0, so the watchdog is disabled and select is 0.
- R10: Register address 0 is control, with bit 0 as watchdog enable and bits 3:1 as timeout select. Address 1 is cause, with bit 0 power-on, bit 1 external, bit 2 brown-out and bit 3 watchdog. Read data is combinational from `reg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| bod_low_i | input | 1 | Supply below brown-out threshold, asynchronous |
| bod_en_i | input | 1 | Brown-out detection enable |
| wdt_clk_i | input | 1 | Slow watchdog clock |
| wdt_srv_i | input | 1 | One-cycle watchdog service strobe (clk_i domain) |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | Register select: 0 control, 1 cause |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| sys_rst_no_o | output | 1 | System reset, active low |

## Verification
The bench walks external pulse widths on both sides of the qualification limit, including the exact limit. A filter that is off by one either accepts a 7-clock glitch or ignores an 8-clock press. It measures the exact length of the reset stretch after power-on and after a brown-out ends. A miscounted hold register shows up there as a reset that is one cycle short or one cycle long.

For the watchdog, the bench shows four things:
- A serviced watchdog stays quiet.
- An unserviced one fires once and then disables itself.
- A larger select value delays the expiry past the point where select 0 would have fired.
- A disabled watchdog never fires.

A lost service crossing would produce spurious resets, and a select that is not decoded would make both timeouts fire at the same time. The cause register is checked for accumulation, partial write-1-to-clear, no effect from writing 0, and the power-on wipe.

// File: rtl/reset_ctrl_pkg.sv
package reset_ctrl_pkg;
  localparam int unsigned CAUSE_N = 4;
  localparam int unsigned C_POR = 0;
  localparam int unsigned C_EXT = 1;
  localparam int unsigned C_BOD = 2;
  localparam int unsigned C_WDT = 3;

  typedef enum logic {
    ADDR_CTRL  = 1'b0,
    ADDR_CAUSE = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rc_width_filter.sv
// Asserts hit_o once active_i has been high for MIN_CYC consecutive clocks.
module rc_width_filter #(
  parameter int unsigned MIN_CYC = 8,
  localparam int unsigned CNT_W = $clog2(MIN_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!active_i)                    cnt_q <= '0;
    else if (cnt_q != CNT_W'(MIN_CYC))     cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == CNT_W'(MIN_CYC));
endmodule

// File: rtl/rc_wdt_core.sv
// Watchdog counter in the wdt clock domain; control inputs are quasi-static.
module rc_wdt_core #(
  parameter int unsigned BASE_LOG2   = 4,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             wdt_clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             srv_tgl_i,
  output logic             exp_tgl_o
);
  logic             wrst_n;
  logic             en_s;
  logic             srv_s;
  logic             srv_d_q;
  logic [SEL_W-1:0] sel_s;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             tgl_q;

  rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(wdt_clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(wrst_n));

  rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
    .clk_i(wdt_clk_i), .rst_ni(wrst_n), .d_i(en_i), .q_o(en_s));

  rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_srv_sync (
    .clk_i(wdt_clk_i), .rst_ni(wrst_n), .d_i(srv_tgl_i), .q_o(srv_s));

  for (genvar i = 0; i < SEL_W; i++) begin : g_sel_sync
    rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sel_sync (
      .clk_i(wdt_clk_i), .rst_ni(wrst_n), .d_i(sel_i[i]), .q_o(sel_s[i]));
  end

  // Period 2^(BASE_LOG2+sel): terminal count is that many ones.
  assign limit = {CNT_W{1'b1}} >> (CNT_W - BASE_LOG2 - 32'(sel_s));

  always_ff @(posedge wdt_clk_i or negedge wrst_n) begin
    if (!wrst_n) begin
      cnt_q   <= '0;
      tgl_q   <= 1'b0;
      srv_d_q <= 1'b0;
    end else begin
      srv_d_q <= srv_s;
      if (!en_s || (srv_s != srv_d_q)) begin
        cnt_q <= '0;
      end else if (cnt_q >= limit) begin
        cnt_q <= '0;
        tgl_q <= ~tgl_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign exp_tgl_o = tgl_q;
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl
  import reset_ctrl_pkg::*;
#(
  parameter int unsigned EXT_MIN_CYC   = 8,
  parameter int unsigned HOLD_CYC      = 16,
  parameter int unsigned WDT_BASE_LOG2 = 4,
  parameter int unsigned WDT_SEL_W     = 3,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned DATA_W = 1 + WDT_SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              bod_low_i,
  input  logic              bod_en_i,
  input  logic              wdt_clk_i,
  input  logic              wdt_srv_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_rst_no_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);

  logic                 ext_n_s, ext_hit;
  logic                 bod_s, bod_hit;
  logic                 exp_tgl, exp_s, exp_d_q, wdt_hit;
  logic                 srv_tgl_q;
  logic                 any_src;
  logic [HOLD_W-1:0]    hold_q;
  logic                 wdt_en_q;
  logic [WDT_SEL_W-1:0] wdt_sel_q;
  logic [CAUSE_N-1:0]   cause_q, cause_d;
  logic                 wr_ctrl, wr_cause;

  // External pin: synchronize, then qualify pulse width
  rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_ni), .q_o(ext_n_s));

  rc_width_filter #(.MIN_CYC(EXT_MIN_CYC)) u_ext_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(~ext_n_s), .hit_o(ext_hit));

  // Brown-out
  rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bod_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bod_low_i), .q_o(bod_s));

  assign bod_hit = bod_s & bod_en_i;

  // Watchdog: service goes out as a toggle, expiry comes back as a toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srv_tgl_q <= 1'b0;
    else         srv_tgl_q <= srv_tgl_q ^ wdt_srv_i;
  end

  rc_wdt_core #(
    .BASE_LOG2(WDT_BASE_LOG2), .SEL_W(WDT_SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_wdt (
    .wdt_clk_i(wdt_clk_i), .rst_ni(rst_ni), .en_i(wdt_en_q), .sel_i(wdt_sel_q),
    .srv_tgl_i(srv_tgl_q), .exp_tgl_o(exp_tgl));

  rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_exp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(exp_tgl), .q_o(exp_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_d_q <= 1'b0;
    else         exp_d_q <= exp_s;
  end

  assign wdt_hit = exp_s ^ exp_d_q;

  // Reset stretch
  assign any_src = ext_hit | bod_hit | wdt_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hold_q <= HOLD_W'(HOLD_CYC);
    else if (any_src)        hold_q <= HOLD_W'(HOLD_CYC);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign sys_rst_no_o = (hold_q == '0);

  // Registers
  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_cause = reg_we_i && (reg_addr_i == ADDR_CAUSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_en_q  <= 1'b0;
      wdt_sel_q <= '0;
    end else if (!sys_rst_no_o) begin
      wdt_en_q  <= 1'b0;
      wdt_sel_q <= '0;
    end else if (wr_ctrl) begin
      {wdt_sel_q, wdt_en_q} <= reg_wdata_i;
    end
  end

  always_comb begin
    cause_d = cause_q;
    if (wr_cause) cause_d = cause_d & ~reg_wdata_i[CAUSE_N-1:0];
    if (ext_hit)  cause_d[C_EXT] = 1'b1;
    if (bod_hit)  cause_d[C_BOD] = 1'b1;
    if (wdt_hit)  cause_d[C_WDT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= CAUSE_N'(1) << C_POR;
    else         cause_q <= cause_d;
  end

  assign reg_rdata_o = (reg_addr_i == ADDR_CTRL) ? {wdt_sel_q, wdt_en_q}
                                                 : DATA_W'(cause_q);
endmodule

// File: rtl/reset_ctrl_chk.sv
module reset_ctrl_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_no_o,
  input logic             bod_en_i,
  input logic             any_src,
  input logic             ext_hit,
  input logic             wdt_hit,
  input logic [3:0]       cause_q,
  input logic             wdt_en_q,
  input logic [SEL_W-1:0] wdt_sel_q
);
  p_src_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_src |=> !sys_rst_no_o);

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no_o) |-> !$past(any_src));

  p_ext_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_q[1]) |-> $past(ext_hit));

  p_bod_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_q[2]) |-> $past(bod_en_i));

  p_wdt_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_q[3]) |-> $past(wdt_hit));

  p_wdt_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_hit |=> !wdt_hit);

  p_ctrl_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no_o |=> (!wdt_en_q && (wdt_sel_q == '0)));
endmodule

bind reset_ctrl reset_ctrl_chk #(.SEL_W(WDT_SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_rst_no_o(sys_rst_no_o),
  .bod_en_i    (bod_en_i),
  .any_src     (any_src),
  .ext_hit     (ext_hit),
  .wdt_hit     (wdt_hit),
  .cause_q     (cause_q),
  .wdt_en_q    (wdt_en_q),
  .wdt_sel_q   (wdt_sel_q)
);

// File: tb/reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module reset_ctrl_tb_top;
  localparam int HOLD = 16;
  localparam int NVEC = 6;
  // External pulse widths (system clocks) and whether a reset is expected (min 8)
  localparam int PW  [NVEC] = '{2, 7, 8, 12, 3, 20};
  localparam bit EXP [NVEC] = '{0, 0, 1, 1, 0, 1};

  logic       clk = 0, wclk = 0;
  logic       rst_ni = 0, ext_rst_ni = 1, bod_low = 0, bod_en = 0, srv = 0;
  logic       we = 0, addr = 0;
  logic [3:0] wdata = 0, rdata;
  logic       sys_rst_no;

  int checks = 0, fails = 0, low_cnt = 0;
  logic [3:0] rd;

  always #2  clk  = ~clk;
  always #20 wclk = ~wclk;

  reset_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .bod_low_i(bod_low),
    .bod_en_i(bod_en), .wdt_clk_i(wclk), .wdt_srv_i(srv), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sys_rst_no_o(sys_rst_no));

  always @(negedge clk) if (!sys_rst_no) low_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rdreg(input logic a, output logic [3:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ext_pulse(input int n);
    @(negedge clk); ext_rst_ni = 0;
    repeat (n) @(negedge clk);
    ext_rst_ni = 1;
  endtask

  task automatic count_low_after(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (sys_rst_no) break;
      n++;
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    int n;
    // R1: power-on
    repeat (3) @(negedge clk);
    chk(sys_rst_no == 0, "R1 reset low during por", sys_rst_no, 0);
    rdreg(1'b1, rd);
    chk(rd == 4'b0001, "R1 cause during por", rd, 1);
    @(negedge clk); rst_ni = 1;
    count_low_after(n);
    chk(n == HOLD - 1, "R1 hold after por", n, HOLD - 1);

    // R8: write 0 has no effect, write 1 clears
    wr(1'b1, 4'h0); rdreg(1'b1, rd);
    chk(rd == 4'b0001, "R8 write zero keeps", rd, 1);
    wr(1'b1, 4'h1); rdreg(1'b1, rd);
    chk(rd == 4'b0000, "R8 w1c clears", rd, 0);

    // R2: pulse width table
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b1, 4'hF);
      low_cnt = 0;
      ext_pulse(PW[i]);
      repeat (40) @(negedge clk);
      chk((low_cnt > 0) == EXP[i], "R2 ext reset seen", low_cnt, int'(EXP[i]));
      rdreg(1'b1, rd);
      chk(rd == (EXP[i] ? 4'b0010 : 4'b0000), "R2 ext cause", rd, EXP[i] ? 2 : 0);
    end

    // R3: brown-out ignored while disabled
    wr(1'b1, 4'hF);
    low_cnt = 0;
    @(negedge clk); bod_low = 1;
    repeat (30) @(negedge clk);
    chk(low_cnt == 0, "R3 bod disabled no reset", low_cnt, 0);
    rdreg(1'b1, rd);
    chk(rd == 4'b0000, "R3 bod disabled no cause", rd, 0);
    // R3/R7: enabled brown-out, exact stretch after release
    @(negedge clk); bod_en = 1;
    repeat (10) @(negedge clk);
    chk(sys_rst_no == 0, "R3 bod enabled resets", sys_rst_no, 0);
    bod_low = 0;
    count_low_after(n);
    chk(n == HOLD + 1, "R7 hold after source release", n, HOLD + 1);
    rdreg(1'b1, rd);
    chk(rd == 4'b0100, "R3 bod cause", rd, 4);

    // R8: accumulation and partial clear
    ext_pulse(20);
    repeat (40) @(negedge clk);
    rdreg(1'b1, rd);
    chk(rd == 4'b0110, "R8 flags accumulate", rd, 6);
    wr(1'b1, 4'b0010); rdreg(1'b1, rd);
    chk(rd == 4'b0100, "R8 partial clear", rd, 4);
    wr(1'b1, 4'hF);

    // R10/R9: control readback then cleared by reset
    wr(1'b0, 4'hB); rdreg(1'b0, rd);
    chk(rd == 4'hB, "R10 control readback", rd, 11);
    ext_pulse(20);
    repeat (40) @(negedge clk);
    rdreg(1'b0, rd);
    chk(rd == 4'h0, "R9 control cleared by reset", rd, 0);
    wr(1'b1, 4'hF);

    // R6: disabled watchdog
    wr(1'b0, 4'b0000);
    low_cnt = 0;
    repeat (600) @(negedge clk);
    chk(low_cnt == 0, "R6 disabled wdt silent", low_cnt, 0);

    // R5: serviced watchdog stays quiet
    wr(1'b0, 4'b0001);
    low_cnt = 0;
    for (int k = 0; k < 12; k++) begin
      repeat (48) @(negedge clk);
      @(negedge clk); srv = 1;
      @(negedge clk); srv = 0;
    end
    chk(low_cnt == 0, "R5 serviced wdt no reset", low_cnt, 0);
    // R4: unserviced expiry
    repeat (400) @(negedge clk);
    chk(low_cnt > 0, "R4 wdt expiry resets", low_cnt, 1);
    rdreg(1'b1, rd);
    chk(rd == 4'b1000, "R4 wdt cause", rd, 8);
    rdreg(1'b0, rd);
    chk(rd == 4'h0, "R9 wdt reset clears control", rd, 0);

    // R4: select 1 doubles the period
    wr(1'b1, 4'hF);
    wr(1'b0, 4'b0011);
    low_cnt = 0;
    repeat (250) @(negedge clk);
    chk(low_cnt == 0, "R4 sel1 not yet expired", low_cnt, 0);
    repeat (300) @(negedge clk);
    chk(low_cnt > 0, "R4 sel1 expired", low_cnt, 1);
    rdreg(1'b1, rd);
    chk(rd == 4'b1000, "R4 sel1 cause", rd, 8);

    // R1: power-on wipes other flags
    @(negedge clk); rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    count_low_after(n);
    rdreg(1'b1, rd);
    chk(rd == 4'b0001, "R1 por wipes flags", rd, 1);

    summary();
  end
endmodule